// File: doc/BRIEF.md
# PWM Minimum Pulse Width Filter

This block sits between a PWM modulator and the output pin driver. Some pulses are too narrow for an external gate driver to follow, and this block stops them from reaching the pin. At each period boundary it takes the programmed period, duty value, deadband and minimum-width threshold. From these it predicts the high and low pulse widths of the coming period. Both widths are reduced by the deadband, which is first converted from system clocks to PWM clocks.

If either predicted width is below the threshold, the output keeps its present level for the whole period and ignores the modulator's edges. If both widths are legal, the registered output follows the modulator. The decision is made only at period boundaries, so a pulse is never cut off partway through.

The prescaler ratio is supplied as a base-2 logarithm. The deadband conversion is therefore a rounding-up shift. A threshold of zero turns filtering off. A duty of zero, or a duty at or above the period, produces no edges, so it always passes.

Top module: `pwm_mpf_top`

## Requirements
- R1: While `rst_ni` is low, and after its release until the first clock with `period_start_i` high, `pwm_o` is 0 and ignores `mod_i`.
- R2: When `min_width_i` is 0 at a period boundary, the filter passes for that period whatever the duty and deadband.
- R3: The expected high width is `duty_i` minus the converted deadband, floored at 0. A high width below `min_width_i` blocks the period. A width equal to the threshold passes.
- R4: The expected low width is `period_i - duty_i` minus the converted deadband, floored at 0. A low width below `min_width_i` blocks the period. A width equal to the threshold passes.
- R5: While a period is blocked, `pwm_o` holds its level on every clock, however `mod_i` moves.
- R6: A blocked output resumes following `mod_i` at the first period boundary at which the settings give legal widths. A duty change between boundaries does not release it early.
- R7: The pass/hold decision is evaluated only on clocks with `period_start_i` high. Settings changed between boundaries have no effect until the next boundary.
- R8: The deadband converted to PWM clocks is `ceil(deadband_i / 2^presc_log2_i)`, that is, rounded up. A shift of 8 or more turns any nonzero 8-bit deadband into 1.
- R9: A `duty_i` of 0, or a `duty_i` greater than or equal to `period_i`, always passes, because such a period has no edge.
- R10: While passing, `pwm_o` equals `mod_i` delayed by exactly one clock. The decision computed on a boundary clock already applies to the `mod_i` sampled on that clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| period_start_i | input | 1 | One-clock strobe from the modulator at the start of each PWM period |
| mod_i | input | 1 | Raw modulator output |
| period_i | input | CNT_W | Period length in PWM clocks |
| duty_i | input | CNT_W | Duty value (high time) in PWM clocks |
| deadband_i | input | DB_W | Deadband in system clocks |
| presc_log2_i | input | SH_W | Base-2 logarithm of system clocks per PWM clock |
| min_width_i | input | CNT_W | Minimum legal pulse width in PWM clocks; 0 disables filtering |
| pwm_o | output | 1 | Filtered output to the pin driver |

## Verification
The bench covers several boundaries of the width comparison:
- Widths exactly equal to the threshold on both the high side and the low side. An off-by-one compare would block these.
- Deadbands that divide evenly by the prescaler ratio and deadbands that do not. Truncating instead of rounding up would pass a pulse one clock too narrow.
- A shift larger than the deadband width, which catches a broken mask.
- Duty values of 0 and of the full period. A filter that treats these as zero-width pulses would leave the output stuck.

The bench also covers the timing of the decision. It changes the duty between boundaries in both directions and checks that nothing happens until the next strobe. A design that evaluated the widths continuously would either cut off a running pulse or release a held output early. Finally, the bench checks the single-clock latency, including the boundary clock itself. A gate that used the stale decision on that clock would lose or add one edge.

// File: rtl/pwm_mpf_pkg.sv
package pwm_mpf_pkg;
  localparam int unsigned CNT_W_DEF = 16;
  localparam int unsigned DB_W_DEF  = 8;
  localparam int unsigned SH_W_DEF  = 4;

  typedef enum logic {
    FILT_HOLD = 1'b0,
    FILT_PASS = 1'b1
  } filt_state_e;
endpackage

// File: rtl/pwm_mpf_db_conv.sv
module pwm_mpf_db_conv #(
  parameter int unsigned DB_W = 8,
  parameter int unsigned SH_W = 4
) (
  input  logic            rst_ni,
  input  logic [DB_W-1:0] db_sys_i,
  input  logic [SH_W-1:0] shift_i,
  output logic [DB_W-1:0] db_pwm_o
);
  localparam int unsigned EXT_W = DB_W + (1 << SH_W);

  logic [DB_W-1:0] frac_mask;
  logic [DB_W-1:0] whole;
  logic            has_frac;

  // shift >= DB_W yields an all-ones mask
  assign frac_mask = (DB_W'(1) << shift_i) - DB_W'(1);
  assign whole     = db_sys_i >> shift_i;
  assign has_frac  = |(db_sys_i & frac_mask);
  assign db_pwm_o  = whole + DB_W'(has_frac);

  logic [EXT_W-1:0] up_ext, dn_ext;
  assign up_ext = EXT_W'(db_pwm_o) << shift_i;
  assign dn_ext = EXT_W'(db_pwm_o - DB_W'(1)) << shift_i;

  always_comb begin
    if (rst_ni && db_pwm_o != '0) begin
      // R8
      db_round_chk: assert (up_ext >= EXT_W'(db_sys_i) && dn_ext < EXT_W'(db_sys_i));
    end
  end
endmodule

// File: rtl/pwm_mpf_width_calc.sv
module pwm_mpf_width_calc #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned DB_W  = 8
) (
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic [DB_W-1:0]  db_pwm_i,
  input  logic [CNT_W-1:0] min_width_i,
  output logic             pass_o
);
  logic [CNT_W-1:0] db_ext;
  logic [CNT_W-1:0] hi_w, lo_raw, lo_w;
  logic             steady, filt_off, hi_ok, lo_ok;

  assign db_ext   = CNT_W'(db_pwm_i);
  assign hi_w     = (duty_i >= db_ext) ? duty_i - db_ext : '0;
  assign lo_raw   = (period_i >= duty_i) ? period_i - duty_i : '0;
  assign lo_w     = (lo_raw >= db_ext) ? lo_raw - db_ext : '0;
  assign steady   = (duty_i == '0) || (duty_i >= period_i);
  assign filt_off = (min_width_i == '0);
  assign hi_ok    = (hi_w >= min_width_i);
  assign lo_ok    = (lo_w >= min_width_i);
  assign pass_o   = filt_off || steady || (hi_ok && lo_ok);

  always_comb begin
    if (rst_ni && !steady && !filt_off && pass_o) begin
      // R3 R4
      width_ok_chk: assert (duty_i >= db_ext + min_width_i
                            && (period_i - duty_i) >= db_ext + min_width_i);
    end
  end
endmodule

// File: rtl/pwm_mpf_gate.sv
module pwm_mpf_gate
  import pwm_mpf_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic period_start_i,
  input  logic pass_i,
  input  logic mod_i,
  output logic pwm_o
);
  filt_state_e state_q, state_d;
  logic        out_q, live;

  assign state_d = pass_i ? FILT_PASS : FILT_HOLD;
  // boundary clock uses the fresh decision so no edge is lost or added
  assign live    = period_start_i ? pass_i : (state_q == FILT_PASS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= FILT_HOLD;
      out_q   <= 1'b0;
    end else begin
      if (period_start_i) state_q <= state_d;
      if (live) out_q <= mod_i;
    end
  end

  assign pwm_o = out_q;

  // R5
  hold_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == FILT_HOLD && !period_start_i) |=> $stable(pwm_o));

  // R10
  follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == FILT_PASS && !period_start_i) |=> (pwm_o == $past(mod_i)));

  // R7
  decision_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !period_start_i |=> $stable(state_q));
endmodule

// File: rtl/pwm_mpf_top.sv
module pwm_mpf_top
  import pwm_mpf_pkg::*;
#(
  parameter int unsigned CNT_W = CNT_W_DEF,
  parameter int unsigned DB_W  = DB_W_DEF,
  parameter int unsigned SH_W  = SH_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             period_start_i,
  input  logic             mod_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic [DB_W-1:0]  deadband_i,
  input  logic [SH_W-1:0]  presc_log2_i,
  input  logic [CNT_W-1:0] min_width_i,
  output logic             pwm_o
);
  logic [DB_W-1:0] db_pwm;
  logic            pass;

  pwm_mpf_db_conv #(.DB_W(DB_W), .SH_W(SH_W)) u_db (
    .rst_ni   (rst_ni),
    .db_sys_i (deadband_i),
    .shift_i  (presc_log2_i),
    .db_pwm_o (db_pwm)
  );

  pwm_mpf_width_calc #(.CNT_W(CNT_W), .DB_W(DB_W)) u_width (
    .rst_ni      (rst_ni),
    .period_i    (period_i),
    .duty_i      (duty_i),
    .db_pwm_i    (db_pwm),
    .min_width_i (min_width_i),
    .pass_o      (pass)
  );

  pwm_mpf_gate u_gate (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .period_start_i (period_start_i),
    .pass_i         (pass),
    .mod_i          (mod_i),
    .pwm_o          (pwm_o)
  );

  // R2
  filt_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (period_start_i && min_width_i == '0) |=> (pwm_o == $past(mod_i)));

  // R9
  steady_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (period_start_i && (duty_i == '0 || duty_i >= period_i)) |=> (pwm_o == $past(mod_i)));
endmodule

// File: tb/pwm_mpf_top_test.sv
module pwm_mpf_top_test;
  localparam int CNT_W = 16;
  localparam int DB_W  = 8;
  localparam int SH_W  = 4;
  localparam int NV    = 15;

  // period, duty, deadband, shift, min, expect_pass, req
  localparam int VEC [0:NV-1][0:6] = '{
    '{100, 50,   0,  0,  0, 1, 2},  // R2 filter off
    '{100, 50,   0,  0, 10, 1, 3},  // R3 legal both sides
    '{100,  5,   0,  0, 10, 0, 3},  // R3 high too short
    '{100, 95,   0,  0, 10, 0, 4},  // R4 low too short
    '{100, 20,  12,  0, 10, 0, 3},  // R3 deadband shortens high
    '{100, 20,  12,  2, 17, 1, 8},  // R8 12/4 = 3 -> hi 17
    '{100, 20,  13,  2, 17, 0, 8},  // R8 ceil(13/4) = 4 -> hi 16
    '{100,  0,   0,  0, 10, 1, 9},  // R9 zero duty
    '{100, 100,  0,  0, 10, 1, 9},  // R9 full duty
    '{100, 10,   0,  0, 10, 1, 3},  // R3 exactly at threshold
    '{100, 90,   0,  0, 10, 1, 4},  // R4 exactly at threshold
    '{100, 91,   0,  0, 10, 0, 4},  // R4 one below
    '{100, 30, 200,  8, 10, 1, 8},  // R8 ceil(200/256) = 1
    '{100, 11, 255, 15, 10, 1, 8},  // R8 large shift -> 1, hi 10
    '{100, 10, 255,  0, 10, 0, 3}   // R3 deadband swallows high
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic period_start_i = 1'b0;
  logic mod_i = 1'b0;
  logic [CNT_W-1:0] period_i = '0;
  logic [CNT_W-1:0] duty_i = '0;
  logic [DB_W-1:0]  deadband_i = '0;
  logic [SH_W-1:0]  presc_log2_i = '0;
  logic [CNT_W-1:0] min_width_i = '0;
  logic pwm_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  pwm_mpf_top #(.CNT_W(CNT_W), .DB_W(DB_W), .SH_W(SH_W)) uut (
    .clk_i, .rst_ni, .period_start_i, .mod_i, .period_i, .duty_i,
    .deadband_i, .presc_log2_i, .min_width_i, .pwm_o
  );

  task automatic chk(input logic got, input logic exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: pwm_o=%0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic set_cfg(input int p, input int d, input int db, input int s, input int mn);
    period_i = CNT_W'(p); duty_i = CNT_W'(d); deadband_i = DB_W'(db);
    presc_log2_i = SH_W'(s); min_width_i = CNT_W'(mn);
  endtask

  // boundary strobe with mod_i held at the current output level
  task automatic boundary(input int p, input int d, input int db, input int s, input int mn);
    set_cfg(p, d, db, s, mn);
    mod_i = pwm_o;
    period_start_i = 1'b1;
    @(negedge clk_i);
    period_start_i = 1'b0;
  endtask

  task automatic probe(input bit pass, input string tag);
    logic prev;
    prev = pwm_o;
    mod_i = ~prev;
    @(negedge clk_i);
    chk(pwm_o, pass ? ~prev : prev, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic lvl;
    repeat (3) @(negedge clk_i);
    chk(pwm_o, 1'b0, "R1 in reset");
    mod_i = 1'b1;
    @(negedge clk_i);
    chk(pwm_o, 1'b0, "R1 mod ignored in reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    @(negedge clk_i);
    chk(pwm_o, 1'b0, "R1 held before first boundary");

    for (int i = 0; i < NV; i++) begin
      boundary(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4]);
      probe(VEC[i][5] != 0, $sformatf("R%0d vec%0d a", VEC[i][6], i));
      probe(VEC[i][5] != 0, $sformatf("R%0d vec%0d b", VEC[i][6], i));
    end

    // R2: short duty passes when threshold is zero
    boundary(100, 3, 0, 0, 0);
    probe(1, "R2 short duty with zero min");

    // R7: mid-period change to a bad duty has no effect
    boundary(100, 50, 0, 0, 10);
    duty_i = 16'd5;
    probe(1, "R7 mid-period bad duty ignored");
    boundary(100, 5, 0, 0, 10);
    probe(0, "R7 bad duty applied at boundary");

    // R6: fix duty mid-period, release only at boundary
    duty_i = 16'd50;
    probe(0, "R6 no early release");
    boundary(100, 50, 0, 0, 10);
    probe(1, "R6 release at boundary");

    // R5: held level across many clocks of toggling
    boundary(100, 95, 0, 0, 10);
    lvl = pwm_o;
    for (int k = 0; k < 6; k++) begin
      mod_i = ~mod_i;
      @(negedge clk_i);
      chk(pwm_o, lvl, "R5 hold across period");
    end

    // R10: one-clock latency, no combinational path
    boundary(100, 50, 0, 0, 10);
    lvl = pwm_o;
    mod_i = ~lvl;
    #2;
    chk(pwm_o, lvl, "R10 no change before edge");
    @(negedge clk_i);
    chk(pwm_o, ~lvl, "R10 change after one edge");

    // R10: boundary clock uses fresh decision (was held, now passing)
    boundary(100, 5, 0, 0, 10);
    lvl = pwm_o;
    set_cfg(100, 50, 0, 0, 10);
    mod_i = ~lvl;
    period_start_i = 1'b1;
    @(negedge clk_i);
    period_start_i = 1'b0;
    chk(pwm_o, ~lvl, "R10 boundary clock passes edge");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule